// File: doc/BRIEF.md
# Comparator Edge-Flag and Interrupt Back End

This block is the digital side of an analog voltage comparator. It takes the comparator decision as one bit that is not synchronous to the system clock, plus an enable input. It returns two outputs. The first is a gated raw copy of the decision. The second is a level that has been passed through a chain of flip-flops clocked by the system clock.

A rising transition of the synchronized level sets a sticky rising flag. A falling transition sets a separate sticky falling flag. Both flags set whether or not any interrupt is enabled.

An interrupt request is formed from three things:
- the flags, each qualified by its own enable bit;
- a source enable bit;
- a global enable input.

Software reaches the block through a small register port:
- It reads and writes the enable bits.
- It reads the level and both flags.
- It clears each flag by writing a one to that flag's bit.

Top module: `cmp_edge_irq`

## Requirements
- R1: `raw_out` equals `cmp_decision` while `cmp_en` is 1 and is 0 while `cmp_en` is 0, with no clock delay.
- R2: `latched_out` follows the decision through a two-flop synchronizer. A change of `cmp_decision` shows on `latched_out` after the second rising clock edge. `latched_out` reads 0 at once while `cmp_en` is 0.
- R3: A 0-to-1 change of the synchronized level sets the rising flag (status bit 1) at the next clock edge. A 1-to-0 change sets the falling flag (status bit 2). Each edge sets only its own flag.
- R4: The flags set even when the per-edge enables, the source enable and the global enable are all 0.
- R5: A flag stays set until a write to address 1 with a 1 in that flag's bit. A write with 0 in the bit leaves the flag unchanged.
- R6: If an edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Raising or lowering `cmp_en` sets no flag. Level changes that happen while `cmp_en` is 0 set no flag.
- R8: `irq_req` = `glb_irq_en` AND source enable AND ((rising flag AND rising enable) OR (falling flag AND falling enable)). It is combinational from those registers and inputs.
- R9: Register map:
  - Address 0 is control, read/write: bit 0 is the rising enable, bit 1 the falling enable, bit 2 the source enable.
  - Address 1 is status: bit 0 is `latched_out`, bit 1 the rising flag, bit 2 the falling flag.
  - All other bits and addresses read 0.
  - Reads are combinational from `reg_addr`.
- R10: Synchronous `rst` clears the control register, both flags, the synchronizer and the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Comparator enable |
| cmp_decision | input | 1 | Asynchronous comparator result (positive input above negative input) |
| glb_irq_en | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| raw_out | output | 1 | Gated unsynchronized comparator output |
| latched_out | output | 1 | Synchronized comparator output |
| irq_req | output | 1 | Interrupt request |

## Verification
The results are due at fixed times after a stimulus:

| Result | When it is due |
|---|---|
| `raw_out` and read data | In the same cycle |
| `latched_out` | After the second rising edge that follows a decision change |
| The edge flag | After the third rising edge |
| `irq_req` | Together with the flag |
| A clearing write | After one edge |

The bench drives every input one time unit after a rising edge and samples one time unit after the edge where the result is due. It also checks that the level is still 0 one edge early, so a missing or extra synchronizer stage is caught. For the set-over-clear check, the clearing write is placed in the exact cycle where the falling-edge pulse is live.

// File: rtl/cmp_edge_pkg.sv
`timescale 1ns/1ps
package cmp_edge_pkg;

    localparam int REG_DW = 8;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;

    localparam int CTL_RISE_IE = 0;
    localparam int CTL_FALL_IE = 1;
    localparam int CTL_SRC_IE  = 2;

    localparam int ST_LEVEL = 0;
    localparam int ST_RISE  = 1;
    localparam int ST_FALL  = 2;
    localparam int USED_BITS = 3;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    typedef struct packed {
        logic src_ie;
        logic fall_ie;
        logic rise_ie;
    } irq_ctrl_t;

    function automatic logic irq_eval(edge_pair_t flags, irq_ctrl_t ctl, logic glb);
        return glb & ctl.src_ie &
               ((flags.rise & ctl.rise_ie) | (flags.fall & ctl.fall_ie));
    endfunction

endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
`timescale 1ns/1ps
module cmp_edge_det
    import cmp_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_en,
    input  logic       level,
    output edge_pair_t edges
);
    logic hist;
    logic armed;

    // History tracks the level every cycle, so on enable it already holds the
    // current value; armed blocks the enable cycle itself.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= 1'b0;
            armed <= 1'b0;
        end else begin
            hist  <= level;
            armed <= cmp_en;
        end
    end

    always_comb begin
        edges.rise = cmp_en & armed &  level & ~hist;
        edges.fall = cmp_en & armed & ~level &  hist;
    end

    p_edge_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({edges.rise, edges.fall}));
    p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !edges.rise);
    p_no_edge_off_r7: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |-> !(edges.rise || edges.fall));
endmodule

// File: rtl/cmp_flag_regs.sv
`timescale 1ns/1ps
module cmp_flag_regs
    import cmp_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  edge_pair_t        edges,
    input  logic              level,
    input  logic              glb_irq_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_req
);
    irq_ctrl_t  ctl;
    edge_pair_t flags;
    edge_pair_t clr;
    logic       unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_DW-1:USED_BITS];

    always_comb begin
        clr.rise = reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_RISE];
        clr.fall = reg_wr && reg_addr == ADDR_STAT && reg_wdata[ST_FALL];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (reg_wr && reg_addr == ADDR_CTRL) begin
            ctl.rise_ie <= reg_wdata[CTL_RISE_IE];
            ctl.fall_ie <= reg_wdata[CTL_FALL_IE];
            ctl.src_ie  <= reg_wdata[CTL_SRC_IE];
        end
    end

    // Hardware set wins over software clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.rise <= (flags.rise & ~clr.rise) | edges.rise;
            flags.fall <= (flags.fall & ~clr.fall) | edges.fall;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTL_RISE_IE] = ctl.rise_ie;
                reg_rdata[CTL_FALL_IE] = ctl.fall_ie;
                reg_rdata[CTL_SRC_IE]  = ctl.src_ie;
            end
            ADDR_STAT: begin
                reg_rdata[ST_LEVEL] = level;
                reg_rdata[ST_RISE]  = flags.rise;
                reg_rdata[ST_FALL]  = flags.fall;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq_req = irq_eval(flags, ctl, glb_irq_en);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> flags.rise);
    p_sticky_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (flags.rise && !clr.rise) |=> flags.rise);
    p_sticky_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (flags.fall && !clr.fall) |=> flags.fall);
    p_irq_global_r8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (glb_irq_en && (flags.rise || flags.fall)));
endmodule

// File: rtl/cmp_edge_irq.sv
`timescale 1ns/1ps
module cmp_edge_irq
    import cmp_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en,
    input  logic              cmp_decision,
    input  logic              glb_irq_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              raw_out,
    output logic              latched_out,
    output logic              irq_req
);
    logic       sync_q;
    edge_pair_t edges;

    assign raw_out = cmp_en & cmp_decision;

    // The synchronizer keeps sampling while disabled, so history is valid on enable.
    cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_decision),
        .q   (sync_q)
    );

    assign latched_out = cmp_en & sync_q;

    cmp_edge_det i_edge (
        .clk    (clk),
        .rst    (rst),
        .cmp_en (cmp_en),
        .level  (sync_q),
        .edges  (edges)
    );

    cmp_flag_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .edges      (edges),
        .level      (latched_out),
        .glb_irq_en (glb_irq_en),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_req    (irq_req)
    );

    p_level_off_r2: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |-> (!latched_out && !raw_out));
    p_rise_needs_level_r3: assert property (@(posedge clk) disable iff (rst)
        edges.rise |-> latched_out);
endmodule

// File: tb/test_cmp_edge_irq.sv
`timescale 1ns/1ps
module test_cmp_edge_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_en = 1'b0;
    logic       cmp_decision = 1'b0;
    logic       glb_irq_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       raw_out, latched_out, irq_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_edge_irq i_cmp_edge_irq (
        .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_decision(cmp_decision),
        .glb_irq_en(glb_irq_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_out(raw_out),
        .latched_out(latched_out), .irq_req(irq_req)
    );

    // {en, dec, exp_raw, exp_latched, exp_rise_flag, exp_fall_flag}
    localparam logic [5:0] VEC [8] = '{
        6'b11_11_10,   // R3 rising
        6'b10_00_01,   // R3 falling
        6'b10_00_00,   // no change
        6'b01_00_00,   // R7 change while disabled
        6'b11_11_00,   // R7 enable with level high
        6'b01_00_00,   // R7 disable with level high
        6'b00_00_00,   // R7 level falls while off
        6'b10_00_00    // enable with level low
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        tick(2);
        // R10 reset state
        rd(2'd0, v); chk("R10 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R10 status", v, 8'h00);
        chk("R10 irq", {7'd0, irq_req}, 8'h00);
        rst = 1'b0;
        cmp_en = 1'b1;
        tick(4);

        for (int k = 0; k < 8; k++) begin
            cmp_en = VEC[k][5];
            cmp_decision = VEC[k][4];
            #1;
            chk("R1 raw", {7'd0, raw_out}, {7'd0, VEC[k][3]});
            tick(3);
            chk("R2 latched", {7'd0, latched_out}, {7'd0, VEC[k][2]});
            rd(2'd1, v);
            chk("R3/R7 status", v, {5'd0, VEC[k][0], VEC[k][1], VEC[k][2]});
            chk("R4 irq masked", {7'd0, irq_req}, 8'h00);
            wr(2'd1, 8'h06);
        end

        // R2/R3/R8 timing from a decision change
        wr(2'd0, 8'h07);
        rd(2'd0, v); chk("R9 ctrl readback", v, 8'h07);
        glb_irq_en = 1'b1;
        cmp_decision = 1'b1;
        tick(1);
        chk("R2 not yet", {7'd0, latched_out}, 8'h00);
        tick(1);
        rd(2'd1, v); chk("R2 level at 2", v, 8'h01);
        chk("R8 irq not yet", {7'd0, irq_req}, 8'h00);
        tick(1);
        rd(2'd1, v); chk("R3 flag at 3", v, 8'h03);
        chk("R8 irq on", {7'd0, irq_req}, 8'h01);

        glb_irq_en = 1'b0; #1;
        chk("R8 global off", {7'd0, irq_req}, 8'h00);
        glb_irq_en = 1'b1;
        wr(2'd0, 8'h03);
        chk("R8 source off", {7'd0, irq_req}, 8'h00);
        wr(2'd0, 8'h06);
        chk("R8 only fall enabled", {7'd0, irq_req}, 8'h00);
        wr(2'd0, 8'h07);
        chk("R8 re-enabled", {7'd0, irq_req}, 8'h01);

        // R5 sticky and write-one-to-clear
        tick(5);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R5 write zero keeps", v, 8'h03);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R5 cleared", v, 8'h01);
        chk("R5 irq drops", {7'd0, irq_req}, 8'h00);

        // R6 set beats clear in the same cycle
        cmp_decision = 1'b0;
        tick(2);
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R6 set wins", v, 8'h04);
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R6 later clear", v, 8'h00);

        // R9 unused addresses
        rd(2'd2, v); chk("R9 addr2", v, 8'h00);
        rd(2'd3, v); chk("R9 addr3", v, 8'h00);

        // R10 reset mid-run
        cmp_decision = 1'b1;
        tick(4);
        rst = 1'b1;
        tick(1);
        rd(2'd0, v); chk("R10 ctrl cleared", v, 8'h00);
        rd(2'd1, v); chk("R10 status cleared", v, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule